// File: doc/BRIEF.md
# Accumulator ALU Slice with Flag Update

This block is the arithmetic and logic slice of a small 8-bit processor core. Each cycle with the valid strobe high, it takes an accumulator byte, an operand byte, a memory byte and the core's current flag nibble. It carries out one of seven operations: load, add with carry, subtract with borrow, AND, OR, bit test or compare. The result byte, the write enables for the accumulator and the memory port, and the new flag nibble are registered on that clock edge.

Each operation class updates only its own subset of the flags. The flags that are not updated pass through from the incoming flag nibble, so the core can keep a carry alive across a chain of multi-byte arithmetic. AND and OR can target memory instead of the accumulator. Bit test and compare compute a hidden value, touch the flags only, and write nothing back. The core supplies the incoming flags and owns the flag register. Instruction decode, address generation and the buses are handled outside this block.

Top module: `acc_alu_slice`

## Requirements
- R1: While reset is asserted, and after it is released with no valid strobe, `res_o`, `flags_o`, `acc_we_o` and `mem_we_o` are all zero.
- R2: Load (op code 0) registers `opnd_i` unchanged into `res_o` and raises `acc_we_o`. Z (flag bit 1) is set when that byte is zero; H (bit 3), V (bit 2) and C (bit 0) equal the incoming flags.
- R3: Add with carry (op code 1) registers `acc_i + opnd_i + C`. C is the carry out of the top bit. H is the carry out of the low half-word (bit W/2-1). V is set on signed overflow, and Z on a zero result. `acc_we_o` is raised. With 3 + 4 and C clear, the result is 7.
- R4: Subtract with borrow (op code 2) registers `acc_i - opnd_i - (1 - C)`. C is set when no borrow occurs. H is set when the low half produces no borrow. V shows signed overflow and Z a zero result. `acc_we_o` is raised.
- R5: AND (op code 3) and OR (op code 4) with `dst_mem_i` low combine `acc_i` with `opnd_i` bit by bit and raise `acc_we_o`. Only Z is updated.
- R6: AND and OR with `dst_mem_i` high combine `mem_i` with `opnd_i`, raise `mem_we_o` and leave `acc_we_o` low. Only Z is updated. The two write enables are never high together.
- R7: Bit test (op code 5) ANDs `opnd_i` with `acc_i`, or with `mem_i` when `dst_mem_i` is high, and updates only Z. No write enable is raised and `res_o` holds its value.
- R8: Compare (op code 6) forms `acc_i - opnd_i`. C is set when `opnd_i <= acc_i`, Z is set only on equality, and C from the incoming flags has no effect. No write enable is raised and `res_o` holds. H and V after a compare are unspecified.
- R9: With `valid_i` low, both write enables are low next cycle and `res_o` and `flags_o` hold.
- R10: Op code 7 raises no write enable, leaves `res_o` held and registers `flags_i` unchanged.
- R11: `dst_mem_i` has no effect on load, add, subtract or compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 load, 1 add, 2 subtract, 3 AND, 4 OR, 5 bit test, 6 compare) |
| dst_mem_i | input | 1 | Memory byte is the target or source for AND, OR and bit test |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Operand byte |
| mem_i | input | W | Memory byte |
| flags_i | input | 4 | Incoming flags {H, V, Z, C} |
| res_o | output | W | Registered result byte |
| acc_we_o | output | 1 | Accumulator write enable |
| mem_we_o | output | 1 | Memory write enable |
| flags_o | output | 4 | Registered flags {H, V, Z, C} |

## Verification
The bench builds the main instance with W = 4, so the half-carry comes from bit 1. This width lets a sweep cover every accumulator and operand pair for all eight op codes, both destinations and both carry-in values. That sweep reaches every carry, borrow, half-carry, overflow and equality boundary, and every case where `dst_mem_i` should have no effect. A second instance at the default W = 8 checks the 3 + 4 addition and the byte-wide overflow and half-carry edges directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADC  = 3'd1,
    OP_SBC  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_BIT  = 3'd5,
    OP_CMP  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  localparam int FLAG_N = 4;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FV = 2;
  localparam int FH = 3;

  // which flags an operation class is allowed to update
  function automatic logic [FLAG_N-1:0] flag_mask(alu_op_e op);
    logic [FLAG_N-1:0] m;
    m = '0;
    unique case (op)
      OP_ADC, OP_SBC, OP_CMP:        m = 4'b1111;
      OP_LOAD, OP_AND, OP_OR, OP_BIT: m[FZ] = 1'b1;
      default:                       m = '0;
    endcase
    return m;
  endfunction

  function automatic logic writes_acc(alu_op_e op, logic dst_mem);
    return (op == OP_LOAD) || (op == OP_ADC) || (op == OP_SBC) ||
           (((op == OP_AND) || (op == OP_OR)) && !dst_mem);
  endfunction

  function automatic logic writes_mem(alu_op_e op, logic dst_mem);
    return ((op == OP_AND) || (op == OP_OR)) && dst_mem;
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hcarry,
  output logic         ovf
);
  localparam int HB = W / 2;

  function automatic logic [W:0] add_full(logic [W-1:0] x, logic [W-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [HB:0] add_low(logic [HB-1:0] x, logic [HB-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{HB{1'b0}}, ci};
  endfunction

  logic [W-1:0]  b_eff;
  logic [W:0]    full;
  logic [HB:0]   low;

  always_comb begin
    b_eff  = sub ? ~b : b;
    full   = add_full(a, b_eff, cin);
    low    = add_low(a[HB-1:0], b_eff[HB-1:0], cin);
    sum    = full[W-1:0];
    cout   = full[W];
    hcarry = low[HB];
    ovf    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 8
) (
  input  alu_pkg::alu_op_e op,
  input  logic             dst_mem,
  input  logic [W-1:0]     acc,
  input  logic [W-1:0]     mem,
  input  logic [W-1:0]     opnd,
  output logic [W-1:0]     lres
);
  import alu_pkg::*;
  logic [W-1:0] src;

  always_comb begin
    src = dst_mem ? mem : acc;
    if (op == OP_OR) lres = src | opnd;
    else             lres = src & opnd;
  end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge (
  input  alu_pkg::alu_op_e            op,
  input  logic [alu_pkg::FLAG_N-1:0]  fin,
  input  logic [alu_pkg::FLAG_N-1:0]  fnew,
  output logic [alu_pkg::FLAG_N-1:0]  upd_mask,
  output logic [alu_pkg::FLAG_N-1:0]  fout
);
  import alu_pkg::*;
  assign upd_mask = flag_mask(op);

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign fout[i] = upd_mask[i] ? fnew[i] : fin[i];
  end
endmodule

// File: rtl/acc_alu_slice.sv
module acc_alu_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         dst_mem_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] mem_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic         acc_we_o,
  output logic         mem_we_o,
  output logic [3:0]   flags_o
);
  import alu_pkg::*;

  alu_op_e       op;
  logic          arith_sub;
  logic          arith_cin;
  logic [W-1:0]  arith_sum;
  logic          arith_c, arith_h, arith_v;
  logic [W-1:0]  logic_res;
  logic [W-1:0]  core_res;
  logic [3:0]    flags_new;
  logic [3:0]    flags_nxt;
  logic [3:0]    upd_mask;
  logic          wr_acc, wr_mem;

  assign op        = alu_op_e'(op_i);
  assign arith_sub = (op == OP_SBC) || (op == OP_CMP);
  assign arith_cin = (op == OP_CMP) ? 1'b1 : flags_i[FC];

  alu_addsub #(.W(W)) u_addsub (
    .a(acc_i), .b(opnd_i), .cin(arith_cin), .sub(arith_sub),
    .sum(arith_sum), .cout(arith_c), .hcarry(arith_h), .ovf(arith_v)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op(op), .dst_mem(dst_mem_i), .acc(acc_i), .mem(mem_i),
    .opnd(opnd_i), .lres(logic_res)
  );

  always_comb begin
    unique case (op)
      OP_LOAD:                core_res = opnd_i;
      OP_ADC, OP_SBC, OP_CMP: core_res = arith_sum;
      OP_AND, OP_OR, OP_BIT:  core_res = logic_res;
      default:                core_res = '0;
    endcase
    flags_new[FH] = arith_h;
    flags_new[FV] = arith_v;
    flags_new[FZ] = (core_res == '0);
    flags_new[FC] = arith_c;
  end

  alu_flag_merge u_merge (
    .op(op), .fin(flags_i), .fnew(flags_new),
    .upd_mask(upd_mask), .fout(flags_nxt)
  );

  assign wr_acc = valid_i && writes_acc(op, dst_mem_i);
  assign wr_mem = valid_i && writes_mem(op, dst_mem_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o    <= '0;
      flags_o  <= '0;
      acc_we_o <= 1'b0;
      mem_we_o <= 1'b0;
    end else begin
      acc_we_o <= wr_acc;
      mem_we_o <= wr_mem;
      if (wr_acc || wr_mem) res_o <= core_res;
      if (valid_i) flags_o <= flags_nxt;
    end
  end
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] opnd_i,
  input logic [3:0]   flags_i,
  input logic [W-1:0] res_o,
  input logic         acc_we_o,
  input logic         mem_we_o,
  input logic [3:0]   flags_o
);
  p_we_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_we_o && mem_we_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !acc_we_o && !mem_we_o && $stable(res_o) && $stable(flags_o));

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd0 |=> acc_we_o && res_o == $past(opnd_i) &&
      flags_o[3] == $past(flags_i[3]) && flags_o[2] == $past(flags_i[2]) &&
      flags_o[0] == $past(flags_i[0]));

  p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (op_i == 3'd3 || op_i == 3'd4) |=>
      flags_o[3] == $past(flags_i[3]) && flags_o[2] == $past(flags_i[2]) &&
      flags_o[0] == $past(flags_i[0]));

  p_zero_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we_o || mem_we_o) |-> flags_o[1] == (res_o == '0));

  p_bit_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd5 |=> !acc_we_o && !mem_we_o && $stable(res_o));

  p_cmp_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd6 |=> !acc_we_o && !mem_we_o && $stable(res_o));

  p_undef_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && op_i == 3'd7 |=> !acc_we_o && !mem_we_o && flags_o == $past(flags_i));
endmodule

bind acc_alu_slice alu_slice_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
  .opnd_i(opnd_i), .flags_i(flags_i), .res_o(res_o),
  .acc_we_o(acc_we_o), .mem_we_o(mem_we_o), .flags_o(flags_o)
);

// File: tb/tb_acc_alu_slice.sv
module tb_acc_alu_slice;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;
  localparam int HM = (1 << (W / 2)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         dst_mem_i = 1'b0;
  logic [W-1:0] acc_i = '0, opnd_i = '0, mem_i = '0;
  logic [3:0]   flags_i = '0;
  logic [W-1:0] res_o;
  logic         acc_we_o, mem_we_o;
  logic [3:0]   flags_o;

  acc_alu_slice #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .dst_mem_i(dst_mem_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .mem_i(mem_i), .flags_i(flags_i),
    .res_o(res_o), .acc_we_o(acc_we_o), .mem_we_o(mem_we_o), .flags_o(flags_o)
  );

  logic         v8 = 1'b0;
  logic [2:0]   op8 = '0;
  logic [7:0]   a8 = '0, b8 = '0, m8 = '0;
  logic [3:0]   f8 = '0;
  logic [7:0]   r8;
  logic         aw8, mw8;
  logic [3:0]   fo8;

  acc_alu_slice #(.W(8)) dut_w8 (
    .clk(clk), .rst_n(rst_n), .valid_i(v8), .op_i(op8), .dst_mem_i(1'b0),
    .acc_i(a8), .opnd_i(b8), .mem_i(m8), .flags_i(f8),
    .res_o(r8), .acc_we_o(aw8), .mem_we_o(mw8), .flags_o(fo8)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int exp_res = 0;
  int exp_flags = 0;

  function automatic int sx(int x);
    return (x > (M >> 1)) ? x - (M + 1) : x;
  endfunction

  function automatic string rq(int op, int dst);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return dst ? "R6" : "R5";
      5: return "R7";
      6: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sweep point: drive at negedge, output registered at posedge, sample next negedge
  task automatic step(int op, int dst, int a, int b, int m, int fin);
    int h, v, z, c, r, aw, mw, mask, s, bin, sv, newf;
    @(negedge clk);
    valid_i = 1'b1; op_i = op[2:0]; dst_mem_i = dst[0];
    acc_i = a[W-1:0]; opnd_i = b[W-1:0]; mem_i = m[W-1:0]; flags_i = fin[3:0];
    h = 0; v = 0; c = 0; r = 0; aw = 0; mw = 0; mask = 0;
    case (op)
      0: begin r = b; aw = 1; mask = 2; end
      1: begin
        s = a + b + (fin & 1); r = s & M; c = s >> W;
        h = (((a & HM) + (b & HM) + (fin & 1)) > HM) ? 1 : 0;
        sv = sx(a) + sx(b) + (fin & 1); v = (sv > (M >> 1) || sv < -((M + 1) / 2)) ? 1 : 0;
        aw = 1; mask = 15;
      end
      2, 6: begin
        bin = (op == 6) ? 0 : 1 - (fin & 1);
        s = a - b - bin; r = s & M; c = (s >= 0) ? 1 : 0;
        h = (((a & HM) - (b & HM) - bin) >= 0) ? 1 : 0;
        sv = sx(a) - sx(b) - bin; v = (sv > (M >> 1) || sv < -((M + 1) / 2)) ? 1 : 0;
        aw = (op == 2) ? 1 : 0; mask = (op == 6) ? 11 : 15; // 6: H,V don't care
      end
      3: begin r = (dst ? m : a) & b; aw = !dst; mw = dst; mask = 2; end
      4: begin r = (dst ? m : a) | b; aw = !dst; mw = dst; mask = 2; end
      5: begin r = (dst ? m : a) & b; mask = 2; end
      default: mask = 0;
    endcase
    z = (r == 0) ? 1 : 0;
    newf = (h << 3) | (v << 2) | (z << 1) | c;
    exp_flags = (newf & mask) | (fin & ~mask & 15);
    if (op == 6) exp_flags = exp_flags & 3;
    if (aw || mw) exp_res = r;
    @(negedge clk);
    check(rq(op, dst), int'(res_o), exp_res);
    check(rq(op, dst), int'(acc_we_o), aw);
    check(rq(op, dst), int'(mem_we_o), mw);
    check(rq(op, dst), (op == 6) ? int'(flags_o & 4'h3) : int'(flags_o), exp_flags);
    valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(res_o), 0); check("R1", int'(flags_o), 0);
    check("R1", int'(acc_we_o | mem_we_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", int'(res_o), 0); check("R1", int'(flags_o), 0);
    check("R1", int'(acc_we_o | mem_we_o), 0);

    // exhaustive sweep; R11: dst varies for every op
    for (int op = 0; op < 8; op++)
      for (int dst = 0; dst < 2; dst++)
        for (int ci = 0; ci < 2; ci++)
          for (int a = 0; a <= M; a++)
            for (int b = 0; b <= M; b++)
              step(op, dst, a, b, (a * 5 + b * 3 + 1) & M,
                   ((a & 1) << 3) | ((b & 1) << 2) | (((a ^ b) >> 1 & 1) << 1) | ci);

    // R9: idle cycle holds everything
    step(4, 0, 5, 10, 0, 4'b1010);
    @(negedge clk);
    flags_i = 4'b0101; op_i = 3'd1; acc_i = 4'h3; opnd_i = 4'h3;
    @(negedge clk);
    check("R9", int'(acc_we_o | mem_we_o), 0);
    check("R9", int'(res_o), 15);
    check("R9", int'(flags_o), 4'b1000);

    // W=8 directed: R3 3+4 with C clear, overflow and half carry edges
    @(negedge clk); v8 = 1'b1; op8 = 3'd1; a8 = 8'd3; b8 = 8'd4; f8 = 4'b0000;
    @(negedge clk); v8 = 1'b0;
    check("R3", int'(r8), 7); check("R3", int'(fo8), 0); check("R3", int'(aw8), 1);
    v8 = 1'b1; a8 = 8'h7F; b8 = 8'h01;
    @(negedge clk); v8 = 1'b0;
    check("R3", int'(r8), 8'h80); check("R3", int'(fo8), 4'b1100);
    v8 = 1'b1; a8 = 8'hFF; b8 = 8'h00; f8 = 4'b0001;
    @(negedge clk); v8 = 1'b0;
    check("R3", int'(r8), 0); check("R3", int'(fo8), 4'b1011);
    v8 = 1'b1; op8 = 3'd6; a8 = 8'h40; b8 = 8'h40; f8 = 4'b0000;
    @(negedge clk); v8 = 1'b0;
    check("R8", int'(fo8 & 4'h3), 3); check("R8", int'(aw8 | mw8), 0);
    v8 = 1'b1; a8 = 8'h40; b8 = 8'h41;
    @(negedge clk); v8 = 1'b0;
    check("R8", int'(fo8 & 4'h3), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule